// File: doc/BRIEF.md
# Serial Configuration Memory Auto-Load Controller

This block fills an on-chip bank of configuration registers from an external serial memory (the 16-bit-organised three-wire kind with chip select, shift clock, data in and data out). After a hardware reset it starts a load by itself. Software can start the same load again at any later time by writing the load code into a two-bit mode field. The load then behaves as if the chip had just come out of reset.

The controller first reads word 0 of the memory and compares it with a fixed signature. If the two are equal, words 1 to N are copied into configuration registers 0 to N-1. If they differ, no further word is read, the copied registers are left at their reset defaults and a sticky flag records the failure. At the end of every load the mode field drops back to normal by itself, and the registers that are not backed by the memory return to their defaults. The same mode field guards ordinary register writes. Writes land only while the field holds the unlock code, and writing the normal code locks the bank again.

The load time is set by the shift-clock divider and the word count, both of which are parameters.

Top module: `cfgrom_autoload`

## Requirements
- R1: While reset is held and a reset-time load is enabled, `busy` is 1 and `mode` reads 01. `busy` stays 1 until that load ends. After the load, `mode` reads 00 and `busy` reads 0.
- R2: Each word is fetched in one serial frame, and frames go to addresses 0, 1, 2, ... in ascending order.
  - `ee_cs` is high for the whole frame and low between frames. `ee_sk` is low whenever `ee_cs` is low.
  - The command goes out on `ee_di`, most significant bit first: the bits 1,1,0 followed by the AW-bit word address. `ee_di` changes only while `ee_sk` is low, and the memory takes it on the rising edge of `ee_sk`.
  - The controller then gives 16 more clock pulses and samples `ee_do`, most significant data bit first, at each falling edge.
- R3: When word 0 equals ID_CODE (0x8129), configuration register i (for i from 0 to LOAD_WORDS-1) holds memory word i+1 after the load.
- R4: When word 0 differs from ID_CODE (for example 0x8128 or 0x0000), only one frame is issued, `id_bad` becomes 1, and registers 0 to LOAD_WORDS-1 read their defaults. The default of register i is DEF_BASE XOR i.
- R5: `id_bad` keeps the outcome of the last load for as long as the block is idle. A later load whose word 0 matches clears it.
- R6: Writing mode code 01 while idle starts a load, and `busy` reads 1 on the clock after the write.
- R7: When any load ends, `mode` returns to 00 without any write. Registers LOAD_WORDS to LOAD_WORDS+RT_REGS-1 return to their defaults, even if software changed them before the load.
- R8: A configuration write changes a register only while `mode` reads 11 (unlock). In any other mode the write is dropped. Writing code 00 or 10 to the mode field locks the bank.
- R9: Mode writes that arrive while `busy` is 1 are dropped. They neither change `mode` nor start a second load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Strobe that writes the mode field |
| cmd_mode | input | 2 | Mode code: 00 normal/lock, 01 load, 10 lock, 11 unlock |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_addr | input | clog2(LOAD_WORDS+RT_REGS) | Configuration register index to write |
| cfg_wdata | input | DW | Write data |
| rd_addr | input | clog2(LOAD_WORDS+RT_REGS) | Configuration register index to read |
| rd_data | output | DW | Combinational read data |
| mode | output | 2 | Current mode field |
| busy | output | 1 | High from trigger until the load completes |
| id_bad | output | 1 | Sticky flag: word 0 of the last load did not match |
| ee_cs | output | 1 | Serial memory chip select |
| ee_sk | output | 1 | Serial memory shift clock |
| ee_di | output | 1 | Serial data towards the memory |
| ee_do | input | 1 | Serial data from the memory |

## Verification
The bench goes after four corner cases, and each has a visible symptom if the design gets it wrong.
- Signature mismatch directly after a good load. A design that skipped the default restore would keep the stale words of the earlier load. A design that kept reading after the mismatch would show up in the frame count.
- A matching load after a mismatch. A flag that never clears would keep reporting the old failure.
- Unlock and mode writes sent during a load. A design that honoured them would either issue a second burst of frames or leave the bank unlocked once the load ends.
- A runtime register changed by software before a load. Its value must be gone afterwards.

// File: rtl/cfgrom_pkg.sv
package cfgrom_pkg;

   typedef enum logic [1:0] {
      MODE_NORMAL = 2'b00,
      MODE_LOAD   = 2'b01,
      MODE_RSVD   = 2'b10,
      MODE_UNLOCK = 2'b11
   } mode_e;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_ISSUE,
      SQ_WAIT,
      SQ_DONE
   } seq_e;

   localparam logic [2:0] RD_OPCODE = 3'b110;

endpackage

// File: rtl/cfgrom_tick.sv
module cfgrom_tick #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);

   generate
      if (DIV < 1) begin : g_bad_div
         $error("cfgrom_tick: DIV must be at least 1");
      end

      if (DIV == 1) begin : g_pass
         assign tick = en;
      end else begin : g_count
         localparam int CW = $clog2(DIV);
         localparam logic [CW-1:0] TOP = CW'(DIV - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (!en || cnt_q == TOP) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + CW'(1);
            end
         end

         assign tick = en && (cnt_q == TOP);
      end
   endgenerate

endmodule

// File: rtl/cfgrom_mw_read.sv
module cfgrom_mw_read
   import cfgrom_pkg::*;
#(
   parameter int AW = 6,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          start,
   input  logic [AW-1:0] addr,
   input  logic          so,
   output logic          cs,
   output logic          sk,
   output logic          di,
   output logic          active,
   output logic          done,
   output logic [DW-1:0] word
);

   localparam int CMD_W = 3 + AW;
   localparam int TOT   = CMD_W + DW;
   localparam int BW    = $clog2(TOT);
   localparam logic [BW-1:0] CMD_END = BW'(CMD_W);
   localparam logic [BW-1:0] CMD_M1  = BW'(CMD_W - 1);
   localparam logic [BW-1:0] LAST    = BW'(TOT - 1);

   generate
      if (DW < 2) begin : g_bad_dw
         $error("cfgrom_mw_read: DW must be at least 2");
      end
   endgenerate

   logic [BW-1:0]    bcnt_q;
   logic [CMD_W-1:0] cmd_q;
   logic [DW-1:0]    word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         cs     <= 1'b0;
         sk     <= 1'b0;
         di     <= 1'b0;
         done   <= 1'b0;
         bcnt_q <= '0;
         cmd_q  <= '0;
         word_q <= '0;
      end else begin
         done <= 1'b0;
         if (!active) begin
            if (start) begin
               active <= 1'b1;
               cs     <= 1'b1;
               sk     <= 1'b0;
               bcnt_q <= '0;
               cmd_q  <= {RD_OPCODE, addr};
               di     <= RD_OPCODE[2];
            end
         end else if (tick) begin
            if (!sk) begin
               sk <= 1'b1;
            end else begin
               sk <= 1'b0;
               if (bcnt_q >= CMD_END) begin
                  word_q <= {word_q[DW-2:0], so};
               end
               if (bcnt_q == LAST) begin
                  active <= 1'b0;
                  cs     <= 1'b0;
                  di     <= 1'b0;
                  done   <= 1'b1;
               end else begin
                  bcnt_q <= bcnt_q + BW'(1);
                  cmd_q  <= {cmd_q[CMD_W-2:0], 1'b0};
                  di     <= (bcnt_q < CMD_M1) ? cmd_q[CMD_W-2] : 1'b0;
               end
            end
         end
      end
   end

   assign word = word_q;

   a_r2_sk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !cs |-> !sk);

   a_r2_di_held_while_sk_high: assert property (@(posedge clk) disable iff (!rst_n)
      sk |-> $stable(di));

   a_r2_frame_closed_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!cs && !active));

endmodule

// File: rtl/cfgrom_regs.sv
module cfgrom_regs #(
   parameter int          NLD      = 4,
   parameter int          NRT      = 2,
   parameter int          DW       = 16,
   parameter int          IW       = 3,
   parameter logic [15:0] DEF_BASE = 16'hC0DE
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          wr_allow,
   input  logic [IW-1:0] wr_idx,
   input  logic [DW-1:0] wr_data,
   input  logic          ld_en,
   input  logic [IW-1:0] ld_idx,
   input  logic [DW-1:0] ld_data,
   input  logic          clr_ld,
   input  logic          clr_rt,
   input  logic [IW-1:0] rd_idx,
   output logic [DW-1:0] rd_data
);

   localparam int NREG = NLD + NRT;

   generate
      if ((1 << IW) < NREG) begin : g_bad_iw
         $error("cfgrom_regs: IW too narrow for register count");
      end
   endgenerate

   logic [NREG-1:0][DW-1:0] regs_q;
   logic                    wr_go;

   assign wr_go = wr_en && wr_allow;

   generate
      for (genvar g = 0; g < NREG; g++) begin : g_reg
         localparam logic [DW-1:0] DV = DW'(DEF_BASE) ^ DW'(g);
         if (g < NLD) begin : g_ld
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  regs_q[g] <= DV;
               end else if (clr_ld) begin
                  regs_q[g] <= DV;
               end else if (ld_en && ld_idx == IW'(g)) begin
                  regs_q[g] <= ld_data;
               end else if (wr_go && wr_idx == IW'(g)) begin
                  regs_q[g] <= wr_data;
               end
            end
         end else begin : g_rt
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  regs_q[g] <= DV;
               end else if (clr_rt) begin
                  regs_q[g] <= DV;
               end else if (wr_go && wr_idx == IW'(g)) begin
                  regs_q[g] <= wr_data;
               end
            end
         end
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NREG; i++) begin
         if (rd_idx == IW'(i)) rd_data = regs_q[i];
      end
   end

   a_r8_locked_bank_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!(wr_en && wr_allow) && !ld_en && !clr_ld && !clr_rt) |=> $stable(regs_q));

endmodule

// File: rtl/cfgrom_autoload.sv
module cfgrom_autoload
   import cfgrom_pkg::*;
#(
   parameter int          AW            = 6,
   parameter int          DW            = 16,
   parameter int          LOAD_WORDS    = 4,
   parameter int          RT_REGS       = 2,
   parameter int          SK_DIV        = 4,
   parameter logic [15:0] ID_CODE       = 16'h8129,
   parameter logic [15:0] DEF_BASE      = 16'hC0DE,
   parameter bit          LOAD_ON_RESET = 1'b1,
   localparam int         NREG          = LOAD_WORDS + RT_REGS,
   localparam int         IW            = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_wr,
   input  logic [1:0]    cmd_mode,
   input  logic          cfg_wr,
   input  logic [IW-1:0] cfg_addr,
   input  logic [DW-1:0] cfg_wdata,
   input  logic [IW-1:0] rd_addr,
   output logic [DW-1:0] rd_data,
   output logic [1:0]    mode,
   output logic          busy,
   output logic          id_bad,
   output logic          ee_cs,
   output logic          ee_sk,
   output logic          ee_di,
   input  logic          ee_do
);

   generate
      if (LOAD_WORDS < 1 || LOAD_WORDS >= (1 << AW)) begin : g_bad_words
         $error("cfgrom_autoload: LOAD_WORDS out of address range");
      end
      if (DW != 16) begin : g_bad_dw
         $error("cfgrom_autoload: only 16-bit memory words supported");
      end
      if (RT_REGS < 0) begin : g_bad_rt
         $error("cfgrom_autoload: RT_REGS must not be negative");
      end
   endgenerate

   localparam logic [AW-1:0] LAST_W = AW'(LOAD_WORDS);

   seq_e          seq_q;
   mode_e         mode_q;
   logic [AW-1:0] widx_q;
   logic [AW-1:0] widx_m1;
   logic          id_bad_q;

   logic          rd_start;
   logic          rd_act;
   logic          rd_done;
   logic [DW-1:0] rd_word;
   logic          tick;

   logic          ld_en;
   logic          clr_rt;
   logic          clr_ld;
   logic          wr_allow;

   // Serial clock pacing, only while a frame is in flight
   cfgrom_tick #(.DIV(SK_DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (rd_act),
      .tick  (tick)
   );

   cfgrom_mw_read #(.AW(AW), .DW(DW)) u_rd (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .start  (rd_start),
      .addr   (widx_q),
      .so     (ee_do),
      .cs     (ee_cs),
      .sk     (ee_sk),
      .di     (ee_di),
      .active (rd_act),
      .done   (rd_done),
      .word   (rd_word)
   );

   // Load sequencer: signature word first, then the mapped words
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq_q    <= LOAD_ON_RESET ? SQ_ISSUE : SQ_IDLE;
         mode_q   <= LOAD_ON_RESET ? MODE_LOAD : MODE_NORMAL;
         widx_q   <= '0;
         id_bad_q <= 1'b0;
      end else begin
         case (seq_q)
            SQ_IDLE: begin
               if (cmd_wr) begin
                  mode_q <= mode_e'(cmd_mode);
                  if (mode_e'(cmd_mode) == MODE_LOAD) begin
                     seq_q  <= SQ_ISSUE;
                     widx_q <= '0;
                  end
               end
            end
            SQ_ISSUE: seq_q <= SQ_WAIT;
            SQ_WAIT: begin
               if (rd_done) begin
                  if (widx_q == '0) begin
                     if (rd_word == DW'(ID_CODE)) begin
                        id_bad_q <= 1'b0;
                        widx_q   <= widx_q + AW'(1);
                        seq_q    <= SQ_ISSUE;
                     end else begin
                        id_bad_q <= 1'b1;
                        seq_q    <= SQ_DONE;
                     end
                  end else if (widx_q == LAST_W) begin
                     seq_q <= SQ_DONE;
                  end else begin
                     widx_q <= widx_q + AW'(1);
                     seq_q  <= SQ_ISSUE;
                  end
               end
            end
            SQ_DONE: begin
               mode_q <= MODE_NORMAL;
               seq_q  <= SQ_IDLE;
            end
            default: seq_q <= SQ_IDLE;
         endcase
      end
   end

   assign rd_start = (seq_q == SQ_ISSUE);
   assign widx_m1  = widx_q - AW'(1);
   assign ld_en    = (seq_q == SQ_WAIT) && rd_done && (widx_q != '0);
   assign clr_rt   = (seq_q == SQ_DONE);
   assign clr_ld   = (seq_q == SQ_DONE) && id_bad_q;
   assign wr_allow = (mode_q == MODE_UNLOCK) && (seq_q == SQ_IDLE);

   cfgrom_regs #(
      .NLD      (LOAD_WORDS),
      .NRT      (RT_REGS),
      .DW       (DW),
      .IW       (IW),
      .DEF_BASE (DEF_BASE)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_wr),
      .wr_allow (wr_allow),
      .wr_idx   (cfg_addr),
      .wr_data  (cfg_wdata),
      .ld_en    (ld_en),
      .ld_idx   (IW'(widx_m1)),
      .ld_data  (rd_word),
      .clr_ld   (clr_ld),
      .clr_rt   (clr_rt),
      .rd_idx   (rd_addr),
      .rd_data  (rd_data)
   );

   assign mode   = mode_q;
   assign busy   = (seq_q != SQ_IDLE);
   assign id_bad = id_bad_q;

   a_r6_trigger_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cmd_wr && cmd_mode == 2'b01) |=> busy);

   a_r7_mode_normal_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (mode == 2'b00));

   a_r9_cmd_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_wr) |=> ((busy && mode == 2'b01) || (!busy && mode == 2'b00)));

   a_r2_cs_only_in_load: assert property (@(posedge clk) disable iff (!rst_n)
      ee_cs |-> busy);

   a_r1_mode_load_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (mode == 2'b01));

endmodule

// File: tb/cfgrom_autoload_tb.sv
module cfgrom_autoload_tb;

   localparam int          CLK_PERIOD = 10;
   localparam int          NLD        = 4;
   localparam int          NRT        = 2;
   localparam int          IW         = 3;
   localparam logic [15:0] SIG        = 16'h8129;
   localparam logic [15:0] DBASE      = 16'hC0DE;

   // {signature word, data seed, expected mismatch flag}
   localparam logic [32:0] VEC [0:4] = '{
      {16'h8129, 16'h2000, 1'b0},
      {16'h8128, 16'h3000, 1'b1},
      {16'h8129, 16'h4A00, 1'b0},
      {16'h0000, 16'h5000, 1'b1},
      {16'h8129, 16'h6C00, 1'b0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_wr = 1'b0;
   logic [1:0]    cmd_mode = 2'b00;
   logic          cfg_wr = 1'b0;
   logic [IW-1:0] cfg_addr = '0;
   logic [15:0]   cfg_wdata = '0;
   logic [IW-1:0] rd_addr = '0;
   logic [15:0]   rd_data;
   logic [1:0]    mode;
   logic          busy;
   logic          id_bad;
   logic          ee_cs, ee_sk, ee_di;
   logic          ee_do = 1'b0;

   int checks = 0;
   int errors = 0;

   // serial memory model
   logic [15:0] mem [0:63];
   int          m_cnt = 0;
   logic [8:0]  m_cmd = '0;
   int          n_rd = 0;
   int          bad_op = 0;
   int          addr_log [0:15];

   always #(CLK_PERIOD/2) clk = ~clk;

   cfgrom_autoload #(
      .SK_DIV     (2),
      .LOAD_WORDS (NLD),
      .RT_REGS    (NRT),
      .ID_CODE    (SIG),
      .DEF_BASE   (DBASE)
   ) u_dut (
      .clk (clk), .rst_n (rst_n),
      .cmd_wr (cmd_wr), .cmd_mode (cmd_mode),
      .cfg_wr (cfg_wr), .cfg_addr (cfg_addr), .cfg_wdata (cfg_wdata),
      .rd_addr (rd_addr), .rd_data (rd_data),
      .mode (mode), .busy (busy), .id_bad (id_bad),
      .ee_cs (ee_cs), .ee_sk (ee_sk), .ee_di (ee_di), .ee_do (ee_do)
   );

   always @(posedge ee_sk or negedge ee_cs) begin
      if (!ee_cs) begin
         m_cnt = 0;
         m_cmd = '0;
         ee_do = 1'b0;
      end else if (m_cnt < 9) begin
         m_cmd = {m_cmd[7:0], ee_di};
         m_cnt++;
         if (m_cnt == 9) begin
            if (m_cmd[8:6] != 3'b110) bad_op++;
            if (n_rd < 16) addr_log[n_rd] = int'(m_cmd[5:0]);
            n_rd++;
         end
      end else begin
         if (m_cnt < 25) ee_do = mem[m_cmd[5:0]][15-(m_cnt-9)];
         m_cnt++;
      end
   end

   function automatic logic [15:0] img(input logic [15:0] seed, input int k);
      return seed + 16'(k) * 16'h0111;
   endfunction

   function automatic logic [15:0] dflt(input int i);
      return DBASE ^ 16'(i);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic fill(input logic [15:0] id, input logic [15:0] seed);
      mem[0] = id;
      for (int k = 1; k < 64; k++) mem[k] = img(seed, k);
   endtask

   task automatic mode_wr(input logic [1:0] m);
      @(negedge clk);
      cmd_wr = 1'b1;
      cmd_mode = m;
      @(negedge clk);
      cmd_wr = 1'b0;
   endtask

   task automatic reg_wr(input int idx, input logic [15:0] d);
      @(negedge clk);
      cfg_wr = 1'b1;
      cfg_addr = IW'(idx);
      cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic reg_chk(input string tag, input int idx, input logic [15:0] exp);
      @(negedge clk);
      rd_addr = IW'(idx);
      #1;
      chk(tag, 32'(rd_data), 32'(exp));
   endtask

   task automatic wait_idle();
      int n = 0;
      while (busy && n < 5000) begin
         @(negedge clk);
         n++;
      end
      chk("load completes", 32'(busy), 32'd0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      fill(SIG, 16'h1000);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset-time load in progress
      chk("R1 busy after reset", 32'(busy), 32'd1);
      chk("R1 mode during load", 32'(mode), 32'd1);
      wait_idle();
      chk("R1 mode after load", 32'(mode), 32'd0);
      chk("R2 frame count", 32'(n_rd), 32'd5);
      for (int k = 0; k < 5; k++) chk("R2 address order", 32'(addr_log[k]), 32'(k));
      chk("R2 opcode", 32'(bad_op), 32'd0);
      chk("R5 flag clear on match", 32'(id_bad), 32'd0);
      for (int i = 0; i < NLD; i++) reg_chk("R3 copied word", i, img(16'h1000, i + 1));
      for (int i = NLD; i < NLD + NRT; i++) reg_chk("R7 runtime default", i, dflt(i));

      // R8: lock protection
      reg_wr(0, 16'h1111);
      reg_chk("R8 locked write dropped", 0, img(16'h1000, 1));
      mode_wr(2'b11);
      chk("R8 unlock mode", 32'(mode), 32'd3);
      reg_wr(0, 16'h1111);
      reg_chk("R8 unlocked write", 0, 16'h1111);
      reg_wr(5, 16'h7777);
      reg_chk("R8 unlocked runtime write", 5, 16'h7777);
      mode_wr(2'b10);
      reg_wr(0, 16'h2222);
      reg_chk("R8 relocked by 10", 0, 16'h1111);
      mode_wr(2'b00);
      reg_wr(5, 16'h2222);
      reg_chk("R8 relocked by 00", 5, 16'h7777);

      // R6 / R9: software trigger, writes during load ignored
      n_rd = 0;
      mode_wr(2'b01);
      chk("R6 busy after trigger", 32'(busy), 32'd1);
      mode_wr(2'b11);
      chk("R9 mode held during load", 32'(mode), 32'd1);
      mode_wr(2'b01);
      reg_wr(1, 16'h3333);
      wait_idle();
      chk("R9 no second load", 32'(n_rd), 32'd5);
      chk("R7 mode cleared", 32'(mode), 32'd0);
      reg_chk("R3 reload overrides", 0, img(16'h1000, 1));
      reg_chk("R9 write during load dropped", 1, img(16'h1000, 2));
      reg_chk("R7 runtime restored", 5, dflt(5));

      // table of images
      for (int v = 0; v < 5; v++) begin
         logic [15:0] id;
         logic [15:0] seed;
         logic        bad;
         {id, seed, bad} = VEC[v];
         fill(id, seed);
         n_rd = 0;
         mode_wr(2'b01);
         wait_idle();
         chk("R4 R5 mismatch flag", 32'(id_bad), 32'(bad));
         chk("R4 frame count", 32'(n_rd), bad ? 32'd1 : 32'd5);
         for (int i = 0; i < NLD; i++)
            reg_chk(bad ? "R4 default kept" : "R3 copied word", i,
                    bad ? dflt(i) : img(seed, i + 1));
         repeat (20) @(negedge clk);
         chk("R5 flag sticky", 32'(id_bad), 32'(bad));
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule